// File: doc/BRIEF.md
# Transmit Start and Collision-Retry Controller

This controller sits on the transmit side of a 10 Mb/s Ethernet-style MAC. Once a frame has been requested, it waits out the interframe gap and checks that the transmit FIFO holds data. It then raises the transmit enable to the serializer and watches the line for collisions. Time is measured in bit times, and every bit time is marked by a one-cycle clock enable.

When a collision occurs, the controller drops the transmit enable. It then pulses a FIFO flush and a DMA-pointer restore so that the frame can be fetched again. Next it waits a number of slot times that an external random source supplies, and then it waits a fresh gap before the next attempt. A sticky collision flag and a 4-bit collision count report what happened. After fifteen retransmissions that all collide, the frame is abandoned: the abort flag is set and the count is forced to zero.

Carrier seen during the gap while the FIFO is still empty makes the node yield the line to the receive path, and the gap starts over. The backoff random source, the preamble generator, the DMA engine and the receiver are separate blocks.

Top module: `tx_launch_ctrl`

## Requirements
- R1: After an accepted request, `tx_en` rises on the clock edge that follows the edge on which the 64th `bit_en` strobe of the gap was sampled, provided `fifo_count` is nonzero at that edge. `tx_en` stays low before that edge.
- R2: If the gap has expired but `fifo_count` is zero, `tx_en` stays low. It rises on the first edge at which `fifo_count` is nonzero.
- R3: During the gap, `carrier_in` high while `fifo_count` is zero makes `rx_yield` high for one cycle and restarts the gap count from zero. `carrier_in` high while the FIFO holds data has no effect on the start time.
- R4: `collision_in` high during transmission drops `tx_en` on that edge. On the same edge `fifo_flush` and `dma_restore` go high for exactly one cycle.
- R5: Each collision sets the sticky `col_seen` flag and raises `col_count` by one.
- R6: After a collision, the controller waits `backoff_slots` slot times of 512 bit times each, then a full 64-bit-time gap. With `bit_en` always high, `tx_en` rises again 67 + 512·S edges after the collision edge, where S is the value of `backoff_slots`.
- R7: The 16th collision of a frame (the 15th retransmission colliding) aborts the frame. On that edge `abort_pulse` and `fifo_flush` are high for one cycle, `dma_restore` stays low, `abort_flag` is set and `col_count` reads 0. No further attempt follows.
- R8: `tx_last` high during transmission drops `tx_en` and gives a one-cycle `done_pulse`. The controller then returns to idle.
- R9: A request accepted in idle clears `col_count`, `col_seen` and `abort_flag`. `tx_req` pulses while a frame is in progress are ignored.
- R10: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per bit time |
| tx_req | input | 1 | Transmit request pulse |
| fifo_count | input | FIFO_W | Bytes currently in the transmit FIFO |
| carrier_in | input | 1 | Carrier sense |
| collision_in | input | 1 | Collision detect |
| tx_last | input | 1 | Serializer has sent the final bit of the frame |
| backoff_slots | input | SLOT_W | Slot times to wait after a collision |
| tx_en | output | 1 | Transmit enable to the serializer |
| fifo_flush | output | 1 | One-cycle FIFO flush request |
| dma_restore | output | 1 | One-cycle request to rewind the DMA pointers |
| rx_yield | output | 1 | One-cycle hand-over of the line to the receiver |
| col_seen | output | 1 | Sticky collision flag |
| abort_flag | output | 1 | Sticky excessive-collision abort flag |
| col_count | output | CNT_W | Collisions in the current frame |
| done_pulse | output | 1 | One-cycle frame-complete indication |
| abort_pulse | output | 1 | One-cycle frame-abandoned indication |

## Verification
The gap is swept with `bit_en` strobing on every cycle, every second cycle and every third cycle. This shows whether the start edge follows the number of strobes rather than the number of cycles. Three further runs tell apart the three possible blockers of a start: an empty FIFO held past the end of the gap, carrier arriving on an empty FIFO, and carrier arriving with data present (which must not move the start). Collision runs use zero and one backoff slot to separate the slot wait from the gap wait. A run of sixteen back-to-back collisions exercises the count limit, the zeroed count after abort, and the absence of a pointer restore on the final collision.

// File: rtl/tx_launch_pkg.sv
package tx_launch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_GAP,
    ST_TRANSMIT,
    ST_COLLIDED,
    ST_BACKOFF,
    ST_DONE,
    ST_ABORT
  } txc_state_t;
endpackage

// File: rtl/tx_gap_timer.sv
// Counts bit-time strobes up to the gap length and holds there.
module tx_gap_timer #(
  parameter int GAP_BITS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic count_en,
  output logic expired
);
  localparam int GW = $clog2(GAP_BITS + 1);
  localparam logic [GW-1:0] GAP_END = GW'(GAP_BITS);

  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      gap_cnt <= '0;
    end else if (count_en && gap_cnt != GAP_END) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign expired = (gap_cnt == GAP_END);
endmodule

// File: rtl/tx_slot_timer.sv
// Post-collision wait: a loaded number of slots, each SLOT_BITS strobes long.
module tx_slot_timer #(
  parameter int SLOT_BITS = 512,
  parameter int SLOT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SLOT_W-1:0] slots_in,
  input  logic              bit_en,
  output logic              finished
);
  localparam int BW = $clog2(SLOT_BITS);
  localparam logic [BW-1:0] BIT_LAST = BW'(SLOT_BITS - 1);

  logic [SLOT_W-1:0] slots_left;
  logic [BW-1:0]     bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_left <= '0;
      bit_cnt    <= '0;
    end else if (load) begin
      slots_left <= slots_in;
      bit_cnt    <= '0;
    end else if (slots_left != '0 && bit_en) begin
      if (bit_cnt == BIT_LAST) begin
        bit_cnt    <= '0;
        slots_left <= slots_left - 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign finished = (slots_left == '0);
endmodule

// File: rtl/tx_retry_counter.sv
// Collision counter for the current frame, with limit detect.
module tx_retry_counter #(
  parameter int CNT_W     = 4,
  parameter int MAX_RETRY = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bump,
  input  logic             wipe,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RETRY);

  always_ff @(posedge clk) begin
    if (rst || clear || wipe) begin
      count <= '0;
    end else if (bump) begin
      count <= count + 1'b1;
    end
  end

  assign at_limit = (count == LIMIT);
endmodule

// File: rtl/tx_launch_ctrl.sv
module tx_launch_ctrl
  import tx_launch_pkg::*;
#(
  parameter int FIFO_W    = 6,
  parameter int SLOT_W    = 4,
  parameter int CNT_W     = 4,
  parameter int GAP_BITS  = 64,
  parameter int SLOT_BITS = 512,
  parameter int MAX_RETRY = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              tx_req,
  input  logic [FIFO_W-1:0] fifo_count,
  input  logic              carrier_in,
  input  logic              collision_in,
  input  logic              tx_last,
  input  logic [SLOT_W-1:0] backoff_slots,
  output logic              tx_en,
  output logic              fifo_flush,
  output logic              dma_restore,
  output logic              rx_yield,
  output logic              col_seen,
  output logic              abort_flag,
  output logic [CNT_W-1:0]  col_count,
  output logic              done_pulse,
  output logic              abort_pulse
);
  txc_state_t st_q, st_n;

  logic fifo_has_data, defer, gap_expired, slot_done, at_limit;
  logic accept_req, bump, wipe;

  assign fifo_has_data = (fifo_count != '0);
  assign defer         = (st_q == ST_WAIT_GAP) && carrier_in && !fifo_has_data;
  assign accept_req    = (st_q == ST_IDLE) && tx_req;

  tx_gap_timer #(.GAP_BITS(GAP_BITS)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .clear    ((st_q != ST_WAIT_GAP) || defer),
    .count_en (bit_en),
    .expired  (gap_expired)
  );

  tx_slot_timer #(.SLOT_BITS(SLOT_BITS), .SLOT_W(SLOT_W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .load     (st_q == ST_COLLIDED),
    .slots_in (backoff_slots),
    .bit_en   (bit_en),
    .finished (slot_done)
  );

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:     if (tx_req) st_n = ST_WAIT_GAP;
      ST_WAIT_GAP: if (gap_expired && fifo_has_data) st_n = ST_TRANSMIT;
      ST_TRANSMIT: begin
        if (collision_in)  st_n = at_limit ? ST_ABORT : ST_COLLIDED;
        else if (tx_last)  st_n = ST_DONE;
      end
      ST_COLLIDED: st_n = ST_BACKOFF;
      ST_BACKOFF:  if (slot_done) st_n = ST_WAIT_GAP;
      ST_DONE:     st_n = ST_IDLE;
      ST_ABORT:    st_n = ST_IDLE;
      default:     st_n = ST_IDLE;
    endcase
  end

  assign bump = (st_q == ST_TRANSMIT) && (st_n == ST_COLLIDED);
  assign wipe = (st_q == ST_TRANSMIT) && (st_n == ST_ABORT);

  tx_retry_counter #(.CNT_W(CNT_W), .MAX_RETRY(MAX_RETRY)) u_retry (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept_req),
    .bump     (bump),
    .wipe     (wipe),
    .count    (col_count),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      tx_en       <= 1'b0;
      fifo_flush  <= 1'b0;
      dma_restore <= 1'b0;
      rx_yield    <= 1'b0;
      col_seen    <= 1'b0;
      abort_flag  <= 1'b0;
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      st_q        <= st_n;
      tx_en       <= (st_n == ST_TRANSMIT);
      fifo_flush  <= (st_n == ST_COLLIDED) || (st_n == ST_ABORT);
      dma_restore <= (st_n == ST_COLLIDED);
      rx_yield    <= defer;
      done_pulse  <= (st_n == ST_DONE);
      abort_pulse <= (st_n == ST_ABORT);
      if (accept_req)     col_seen <= 1'b0;
      else if (bump || wipe) col_seen <= 1'b1;
      if (accept_req)     abort_flag <= 1'b0;
      else if (wipe)      abort_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_launch_ctrl_chk.sv
module tx_launch_ctrl_chk #(
  parameter int FIFO_W = 6,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_req,
  input logic [FIFO_W-1:0] fifo_count,
  input logic              tx_en,
  input logic              fifo_flush,
  input logic              dma_restore,
  input logic              col_seen,
  input logic              abort_flag,
  input logic [CNT_W-1:0]  col_count,
  input logic              done_pulse,
  input logic              abort_pulse
);
  p_start_needs_data_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> $past(fifo_count) != '0);

  p_restore_with_flush_r4: assert property (@(posedge clk) disable iff (rst)
    dma_restore |-> (fifo_flush && !tx_en));

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_restore) |-> (col_count == CNT_W'($past(col_count) + 1'b1)) && col_seen);

  p_sticky_col_r5: assert property (@(posedge clk) disable iff (rst)
    (col_seen && !tx_req) |=> col_seen);

  p_abort_zero_r7: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> (col_count == '0 && abort_flag && fifo_flush && !dma_restore));

  p_single_done_r8: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  p_exclusive_ends_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_pulse, abort_pulse, tx_en}));
endmodule

bind tx_launch_ctrl tx_launch_ctrl_chk #(.FIFO_W(FIFO_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tx_launch_ctrl_test.sv
`timescale 1ns/1ps
module tx_launch_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0, tx_req = 1'b0, carrier_in = 1'b0;
  logic       collision_in = 1'b0, tx_last = 1'b0;
  logic [5:0] fifo_count = '0;
  logic [3:0] backoff_slots = '0;
  logic       tx_en, fifo_flush, dma_restore, rx_yield, col_seen, abort_flag;
  logic       done_pulse, abort_pulse;
  logic [3:0] col_count;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tx_launch_ctrl uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_req(tx_req),
    .fifo_count(fifo_count), .carrier_in(carrier_in),
    .collision_in(collision_in), .tx_last(tx_last),
    .backoff_slots(backoff_slots), .tx_en(tx_en), .fifo_flush(fifo_flush),
    .dma_restore(dma_restore), .rx_yield(rx_yield), .col_seen(col_seen),
    .abort_flag(abort_flag), .col_count(col_count), .done_pulse(done_pulse),
    .abort_pulse(abort_pulse)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic request();
    tx_req = 1'b1;
    step();
    tx_req = 1'b0;
  endtask

  task automatic finish_frame();
    tx_last = 1'b1;
    step();
    tx_last = 1'b0;
    check("R8 done pulse", done_pulse, 1);
    check("R8 tx_en drop", tx_en, 0);
    step();
    check("R8 done one cycle", done_pulse, 0);
  endtask

  task automatic hit_collision();
    collision_in = 1'b1;
    step();
    collision_in = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    // R10 reset state
    check("R10 tx_en", tx_en, 0);
    check("R10 flags", {fifo_flush, dma_restore, rx_yield, col_seen, abort_flag}, 0);
    check("R10 pulses", {done_pulse, abort_pulse}, 0);
    check("R10 count", col_count, 0);
    rst = 1'b0;
    step();

    // R1 sweep of strobe spacing; carrier with data present is ignored (R3)
    for (int div = 1; div <= 3; div++) begin
      fifo_count = 6'd3;
      request();
      for (int k = 0; k <= 64 * div; k++) begin
        bit_en = ((k % div) == div - 1);
        carrier_in = (div == 2 && k == 20);
        step();
        if (k == 64 * div - 1) check("R1 before gap end", tx_en, 0);
        if (k == 64 * div)     check("R1 start edge", tx_en, 1);
        if (div == 2 && k == 20) check("R3 no yield with data", rx_yield, 0);
      end
      carrier_in = 1'b0;
      bit_en = 1'b1;
      finish_frame();
    end

    // R2 empty FIFO at gap end
    fifo_count = '0;
    bit_en = 1'b1;
    request();
    for (int k = 0; k < 70; k++) step();
    check("R2 held while empty", tx_en, 0);
    fifo_count = 6'd1;
    step();
    check("R2 start on data", tx_en, 1);
    finish_frame();

    // R3 carrier on empty FIFO restarts the gap
    fifo_count = '0;
    request();
    for (int k = 0; k <= 95; k++) begin
      carrier_in = (k == 30);
      if (k == 31) fifo_count = 6'd2;
      step();
      if (k == 30) check("R3 yield", rx_yield, 1);
      if (k == 31) check("R3 yield one cycle", rx_yield, 0);
      if (k == 94) check("R3 gap restarted", tx_en, 0);
      if (k == 95) check("R3 start after restart", tx_en, 1);
    end
    carrier_in = 1'b0;

    // R4, R5, R6 collisions with zero and one backoff slot
    for (int s = 0; s <= 1; s++) begin
      backoff_slots = 4'(s);
      hit_collision();
      check("R4 tx_en drop", tx_en, 0);
      check("R4 flush", fifo_flush, 1);
      check("R4 restore", dma_restore, 1);
      check("R5 count", col_count, s + 1);
      check("R5 sticky flag", col_seen, 1);
      step();
      check("R4 flush one cycle", {fifo_flush, dma_restore}, 0);
      for (int c = 2; c <= 67 + 512 * s; c++) begin
        tx_req = (c == 10);
        step();
        tx_req = 1'b0;
        if (c == 10) check("R9 request ignored while busy", col_count, s + 1);
        if (c == 66 + 512 * s) check("R6 still waiting", tx_en, 0);
        if (c == 67 + 512 * s) check("R6 retry edge", tx_en, 1);
      end
    end
    finish_frame();
    check("R5 flag stays after done", col_seen, 1);
    check("R5 count stays after done", col_count, 2);

    // R9 clear, then R7 sixteen collisions
    backoff_slots = '0;
    request();
    check("R9 count cleared", col_count, 0);
    check("R9 flag cleared", col_seen, 0);
    for (int n = 1; n <= 16; n++) begin
      for (int w = 0; w < 200 && !tx_en; w++) step();
      hit_collision();
      if (n < 16) begin
        check("R5 running count", col_count, n);
        check("R4 restore per retry", dma_restore, 1);
      end else begin
        check("R7 abort pulse", abort_pulse, 1);
        check("R7 abort flag", abort_flag, 1);
        check("R7 count zero", col_count, 0);
        check("R7 flush", fifo_flush, 1);
        check("R7 no restore", dma_restore, 0);
      end
    end
    step();
    check("R7 abort one cycle", abort_pulse, 0);
    for (int k = 0; k < 100; k++) begin
      step();
      if (tx_en) check("R7 no further attempt", tx_en, 0);
    end
    check("R7 flag held", abort_flag, 1);
    request();
    check("R9 abort flag cleared", abort_flag, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule